// File: doc/BRIEF.md
# Feed-Sequence Protected Watchdog Timer

This block is a memory-mapped watchdog for a system that must be pulled back into reset when its software stops responding. Software programs a reload value, sets an enable bit and then proves it is alive by writing a two-byte key pair to a feed register. Only a complete, uninterrupted key pair reloads the down-counter. The counter advances on the input clock divided by four, and when it runs out the block flags the event and, if reset-on-timeout is selected, asks the system for a reset.

The enable bit alone does nothing: the watchdog arms on the first valid key pair written after enable is set, and from then on it cannot be switched off. An armed watchdog also treats any malformed or interrupted key pair as a fault and requests a reset immediately. Only the block's own synchronous reset (the system reset) clears the enable, the selection bits, the timeout flag and the armed state.

Top module: `wdg_timer`

## Requirements
- R1: After reset the mode register reads 0, the reload register reads 0xFF, the counter reads 0xFF and `rst_req` is low.
- R2: Registers are selected by byte address: 0x00 mode (bit 0 enable, bit 1 reset-on-timeout select, bit 2 timeout flag, read-only), 0x04 reload value (24 bits, upper read bits zero), 0x08 feed (write-only, reads 0), 0x0C current counter (read-only); read data appears on `bus_rdata` in the cycle after `bus_re` is sampled.
- R3: A reload write takes `bus_wdata[23:0]`; values below 0xFF are stored as 0xFF, all others are stored unchanged.
- R4: The enable and reset-select bits are set-only: writing 0 to either leaves it at 1 until reset.
- R5: A valid feed is a feed write with low byte 0xAA followed, as the very next bus access, by a feed write with low byte 0x55; it reloads the counter from the reload register and restarts the divide-by-four prescaler, and raises no reset request.
- R6: The counter does not move until the block is armed; the block arms on a valid feed completed while enable is already set, and never disarms except by reset.
- R7: An armed counter decrements once every 4 clocks after a feed; with reset-select set, `rst_req` is high for exactly one cycle, first seen after exactly 4 x reload clock edges following the feed write edge, and mode bit 2 becomes 1 while the counter reads 0.
- R8: On expiry with reset-select clear, mode bit 2 is set, the counter stays at 0 and `rst_req` stays low.
- R9: While armed, a second feed write whose low byte is not 0x55 (for example 0xAA then 0xAA) makes `rst_req` high in the cycle after that write.
- R10: While armed, a first feed write whose low byte is not 0xAA makes `rst_req` high in the cycle after that write.
- R11: Any other bus access (read of any register, or write to another register) between the two feed writes aborts the pair: unarmed, the pending 0xAA is dropped with no request and a following 0x55 does not reload; armed, the interrupting access makes `rst_req` high in the next cycle.
- R12: The timeout flag stays set through later feeds and mode writes and is cleared only by reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Watchdog and bus clock |
| rst | input | 1 | Synchronous active-high system reset |
| bus_addr | input | ADDR_W (4) | Byte address of the register accessed |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_we | input | 1 | Write strobe, one access per asserted cycle |
| bus_re | input | 1 | Read strobe, one access per asserted cycle |
| bus_rdata | output | DATA_W (32) | Registered read data |
| rst_req | output | 1 | One-cycle reset request pulse |

## Verification
A corrupted armed or pending-key state shows at the ports within one bus access: a valid feed that pulses `rst_req`, or an aborted pair that does not, is visible in the cycle after the offending write. A prescaler or counter fault shows as a counter read that differs from reload minus the elapsed quarter-cycles, swept over every phase of the divider, and as a timeout pulse whose edge count after the feed differs from four times the reload value. A lost sticky bit shows on the next mode read after a zero is written to it.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
  localparam logic [1:0] REG_MODE  = 2'd0;
  localparam logic [1:0] REG_TLOAD = 2'd1;
  localparam logic [1:0] REG_FEED  = 2'd2;
  localparam logic [1:0] REG_COUNT = 2'd3;

  localparam logic [7:0] FEED_KEY1 = 8'hAA;
  localparam logic [7:0] FEED_KEY2 = 8'h55;

  typedef struct packed {
    logic flag;
    logic rsel;
    logic en;
  } mode_t;
endpackage

// File: rtl/wdg_prescale.sv
module wdg_prescale #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  output logic tick
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] phase;

  always_ff @(posedge clk) begin
    if (rst || clr) phase <= '0;
    else if (phase == LAST) phase <= '0;
    else phase <= phase + 1'b1;
  end

  assign tick = (phase == LAST);

  AST_PHASE_RANGE: assert property (@(posedge clk) disable iff (rst)
    phase <= LAST); // R7
endmodule

// File: rtl/wdg_feed_seq.sv
module wdg_feed_seq
  import wdg_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_feed,
  input  logic [7:0] key,
  input  logic       other_acc,
  input  logic       armed,
  output logic       feed_ok,
  output logic       feed_bad
);
  logic pending;
  logic is_key1, is_key2;

  assign is_key1 = (key == FEED_KEY1);
  assign is_key2 = (key == FEED_KEY2);

  always_ff @(posedge clk) begin
    if (rst) pending <= 1'b0;
    else if (wr_feed) pending <= !pending && is_key1;
    else if (other_acc) pending <= 1'b0;
  end

  assign feed_ok = wr_feed && pending && is_key2;

  always_comb begin
    feed_bad = 1'b0;
    if (armed) begin
      if (wr_feed && pending && !is_key2) feed_bad = 1'b1;
      if (wr_feed && !pending && !is_key1) feed_bad = 1'b1;
      if (!wr_feed && other_acc && pending) feed_bad = 1'b1;
    end
  end

  AST_OK_NOT_BAD: assert property (@(posedge clk) disable iff (rst)
    !(feed_ok && feed_bad)); // R5
  AST_PEND_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (other_acc && !wr_feed) |=> !pending); // R11
endmodule

// File: rtl/wdg_down_cnt.sv
module wdg_down_cnt #(
  parameter int CNT_W = 24,
  parameter logic [CNT_W-1:0] RST_VAL = '1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             run,
  input  logic             tick,
  output logic [CNT_W-1:0] cnt,
  output logic             expire
);
  logic step;
  assign step = run && tick && (cnt != '0);

  always_ff @(posedge clk) begin
    if (rst) cnt <= RST_VAL;
    else if (load) cnt <= load_val;
    else if (step) cnt <= cnt - 1'b1;
  end

  assign expire = step && !load && (cnt == CNT_W'(1));

  AST_CNT_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (!load && !run) |=> $stable(cnt)); // R6
  AST_ZERO_STAYS: assert property (@(posedge clk) disable iff (rst)
    (!load && cnt == '0) |=> cnt == '0); // R8
endmodule

// File: rtl/wdg_timer.sv
module wdg_timer
  import wdg_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int DATA_W   = 32,
  parameter int CNT_W    = 24,
  parameter int PRESCALE = 4,
  parameter int TC_MIN   = 255
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_we,
  input  logic              bus_re,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              rst_req
);
  localparam int IDX_LSB = 2;
  localparam logic [CNT_W-1:0] TC_MIN_V = CNT_W'(TC_MIN);

  logic [1:0]       sel;
  logic             wr_feed, other_acc;
  logic             feed_ok, feed_bad;
  logic             tick, expire;
  logic             armed;
  mode_t            mode;
  logic [CNT_W-1:0] tload, cnt, wr_val, clamped;
  logic             unused_bits;

  assign sel       = bus_addr[IDX_LSB+1:IDX_LSB];
  assign wr_feed   = bus_we && (sel == REG_FEED);
  assign other_acc = bus_re || (bus_we && (sel != REG_FEED));
  assign wr_val    = bus_wdata[CNT_W-1:0];
  assign clamped   = (wr_val < TC_MIN_V) ? TC_MIN_V : wr_val;
  assign unused_bits = ^{bus_addr[IDX_LSB-1:0], bus_wdata[DATA_W-1:CNT_W]};

  wdg_prescale #(.DIV(PRESCALE)) u_pre (
    .clk(clk), .rst(rst), .clr(feed_ok), .tick(tick)
  );

  wdg_feed_seq u_seq (
    .clk(clk), .rst(rst), .wr_feed(wr_feed), .key(bus_wdata[7:0]),
    .other_acc(other_acc), .armed(armed),
    .feed_ok(feed_ok), .feed_bad(feed_bad)
  );

  wdg_down_cnt #(.CNT_W(CNT_W), .RST_VAL(TC_MIN_V)) u_cnt (
    .clk(clk), .rst(rst), .load(feed_ok), .load_val(tload),
    .run(armed), .tick(tick), .cnt(cnt), .expire(expire)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mode <= '0;
    end else begin
      if (bus_we && sel == REG_MODE) begin
        mode.en   <= mode.en   | bus_wdata[0];
        mode.rsel <= mode.rsel | bus_wdata[1];
      end
      if (expire) mode.flag <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) tload <= TC_MIN_V;
    else if (bus_we && sel == REG_TLOAD) tload <= clamped;
  end

  always_ff @(posedge clk) begin
    if (rst) armed <= 1'b0;
    else if (feed_ok && mode.en) armed <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) rst_req <= 1'b0;
    else rst_req <= (expire && mode.rsel) || feed_bad;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_re) begin
      case (sel)
        REG_MODE:  bus_rdata <= DATA_W'(mode);
        REG_TLOAD: bus_rdata <= DATA_W'(tload);
        REG_COUNT: bus_rdata <= DATA_W'(cnt);
        default:   bus_rdata <= '0;
      endcase
    end
  end

  AST_EN_STICKY: assert property (@(posedge clk) disable iff (rst)
    mode.en |=> mode.en); // R4
  AST_RSEL_STICKY: assert property (@(posedge clk) disable iff (rst)
    mode.rsel |=> mode.rsel); // R4
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
    mode.flag |=> mode.flag); // R12
  AST_ARM_STICKY: assert property (@(posedge clk) disable iff (rst)
    armed |=> armed); // R6
  AST_ARM_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
    armed |-> mode.en); // R6
  AST_REQ_NEEDS_ARM: assert property (@(posedge clk) disable iff (rst)
    rst_req |-> $past(armed)); // R9
  AST_TLOAD_FLOOR: assert property (@(posedge clk) disable iff (rst)
    tload >= TC_MIN_V); // R3
  AST_FLAG_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
    $rose(mode.flag) |-> cnt == '0); // R7
endmodule

// File: tb/tb_wdg_timer.sv
module tb_wdg_timer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_we = 1'b0;
  logic        bus_re = 1'b0;
  logic [31:0] bus_rdata;
  logic        rst_req;

  int checks = 0;
  int errors = 0;
  logic req_seen;
  logic [31:0] rv;

  wdg_timer dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata), .rst_req(rst_req)
  );

  always #5 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); @(negedge clk); rst = 1'b0;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk); bus_we = 1'b0; req_seen = rst_req;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_re = 1'b1;
    @(negedge clk); bus_re = 1'b0; d = bus_rdata; req_seen = rst_req;
  endtask

  task automatic feed();
    wr(4'h8, 32'hAA);
    wr(4'h8, 32'h55);
  endtask

  initial begin
    #1_500_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    do_reset();
    // R1 reset state, R2 map
    chk("R1 rst_req", {31'd0, rst_req}, 32'd0);
    rd(4'h0, rv); chk("R1 mode", rv, 32'd0);
    rd(4'h4, rv); chk("R1 reload", rv, 32'hFF);
    rd(4'hC, rv); chk("R1 count", rv, 32'hFF);
    rd(4'h8, rv); chk("R2 feed reads 0", rv, 32'd0);

    // R3 clamp sweep
    begin
      logic [31:0] vals [8];
      vals = '{32'h0, 32'h1, 32'h80, 32'hFE, 32'hFF, 32'h100, 32'hFFFFFF, 32'h1FFFFFF};
      foreach (vals[i]) begin
        logic [31:0] e;
        e = vals[i] & 32'hFFFFFF;
        if (e < 32'hFF) e = 32'hFF;
        wr(4'h4, vals[i]); rd(4'h4, rv);
        chk("R3 reload clamp", rv, e);
      end
    end

    // R5 reload while unarmed, R6 counter frozen
    wr(4'h4, 32'h200); feed();
    chk("R5 unarmed feed no req", {31'd0, req_seen}, 32'd0);
    rd(4'hC, rv); chk("R5 reload on feed", rv, 32'h200);
    wr(4'h0, 32'h1);
    repeat (100) @(negedge clk);
    rd(4'hC, rv); chk("R6 enable alone frozen", rv, 32'h200);

    // R11 unarmed abort
    wr(4'h4, 32'h300);
    wr(4'h8, 32'hAA); rd(4'h0, rv);
    chk("R11 unarmed abort no req", {31'd0, req_seen}, 32'd0);
    wr(4'h8, 32'h55);
    chk("R11 lone key2 no req", {31'd0, req_seen}, 32'd0);
    rd(4'hC, rv); chk("R11 no reload after abort", rv, 32'h200);
    wr(4'h8, 32'hAA); wr(4'h8, 32'hAA);
    chk("R9 unarmed bad pair no req", {31'd0, req_seen}, 32'd0);
    wr(4'h8, 32'h11);

    // R4 set-only bits
    wr(4'h0, 32'h0); rd(4'h0, rv); chk("R4 enable kept", rv, 32'h1);
    wr(4'h0, 32'h2); rd(4'h0, rv); chk("R4 rsel set", rv, 32'h3);
    wr(4'h0, 32'h0); rd(4'h0, rv); chk("R4 both kept", rv, 32'h3);

    // R7 rate sweep over divider phases; arms on first feed (R6)
    for (int d = 0; d < 16; d++) begin
      feed();
      chk("R5 armed valid feed no req", {31'd0, req_seen}, 32'd0);
      repeat (d) @(negedge clk);
      rd(4'hC, rv);
      chk("R7 count step", rv, 32'h300 - ((d + 1) / 4));
    end

    // R9 / R10 / R11 armed faults
    feed();
    wr(4'h8, 32'hAA); wr(4'h8, 32'hAA);
    chk("R9 key1 key1 req", {31'd0, req_seen}, 32'd1);
    @(negedge clk); chk("R9 pulse one cycle", {31'd0, rst_req}, 32'd0);
    wr(4'h8, 32'h12);
    chk("R10 bad first key req", {31'd0, req_seen}, 32'd1);
    wr(4'h8, 32'hAA); rd(4'hC, rv);
    chk("R11 armed abort req", {31'd0, req_seen}, 32'd1);
    wr(4'h8, 32'hAA); wr(4'h4, 32'h104);
    chk("R11 armed abort by write req", {31'd0, req_seen}, 32'd1);

    // R7 timeout with reset select
    rd(4'h4, rv); chk("R3 reload 0x104", rv, 32'h104);
    feed();
    begin
      int n = 0;
      while (n < 5000) begin
        @(posedge clk); n++;
        @(negedge clk);
        if (rst_req) break;
      end
      chk("R7 expiry edge count", n, 4 * 32'h104);
      @(negedge clk); chk("R7 single pulse", {31'd0, rst_req}, 32'd0);
    end
    rd(4'h0, rv); chk("R7 flag set", rv, 32'h7);
    rd(4'hC, rv); chk("R7 count zero", rv, 32'h0);

    // R12 sticky flag
    feed(); wr(4'h0, 32'h0);
    rd(4'h0, rv); chk("R12 flag kept", rv, 32'h7);

    // R8 expiry without reset select
    do_reset();
    rd(4'h0, rv); chk("R12 reset clears flag", rv, 32'h0);
    wr(4'h0, 32'h1); feed();
    begin
      int hits = 0;
      for (int k = 0; k < 4 * 255 + 40; k++) begin
        @(negedge clk);
        if (rst_req) hits++;
      end
      chk("R8 no request", hits, 0);
    end
    rd(4'h0, rv); chk("R8 flag set", rv, 32'h5);
    rd(4'hC, rv); chk("R8 count stays 0", rv, 32'h0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule